// File: doc/BRIEF.md
# Split Coarse/Fine Complex Transmit Delay

This block delays one complex I/Q transmit stream by a programmable amount, and it does this in two stages. The coarse stage works on the stream at twice the input sample rate. A strobe marks each sample at that rate. The coarse stage moves the stream in steps of half an input period.

A sample-hold upsampler follows the coarse stage. It repeats each sample for `L` clock cycles, which brings the stream to the converter clock rate. The fine stage then adds a delay of a whole number of converter clock cycles. I and Q travel packed together through every register, so they always receive the same delay.

Each transmit channel uses its own instance, with its own two setting fields. A new setting is captured on the next strobe, and the block does not need a reset for it. Samples already held in the delay lines are kept, so the outputs never carry unknown values.

Top module: `tx_iq_delay_split`

## Requirements
- R1: A synchronous active-low reset clears every delay stage. `out_i` and `out_q` read 0 in the cycle after a reset edge and stay 0 until a new sample passes through. Samples already in flight before the reset never appear.
- R2: Suppose a nonzero sample is captured at the rising edge where `hs_valid` is high. The sample is output after edge number 3 + coarse·L + fine, counting from that edge. The fixed pipeline latency is 3 clocks.
- R3: `coarse_dly` is a 3-bit count of coarse steps. Values 0 to 4 select that many steps, and values 5, 6 and 7 act exactly like 4.
- R4: The coarse stage advances only on edges where `hs_valid` is high. The upsampler presents each coarse-stage sample for exactly L consecutive clock cycles.
- R5: `fine_dly` is a 5-bit count of converter clock cycles, from 0 to 31. Each count adds exactly one clock of delay after the upsampler.
- R6: I and Q receive an identical delay. An impulse sent on both lanes appears on `out_i` and `out_q` in the same cycles, with the values that were sent.
- R7: Both fields are captured on the `hs_valid` edge. A value changed on the same edge as the sample it governs already applies to that sample, with no reset in between. The outputs never show unknown values.
- R8: One coarse step equals half an input period, which is L converter clocks. Each extra coarse step moves the output by exactly L clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_valid | input | 1 | Strobe marking a sample at twice the input rate, high for one clock every L clocks |
| in_i | input | DW | In-phase input sample |
| in_q | input | DW | Quadrature input sample |
| coarse_dly | input | 3 | Coarse delay in half-input-period steps (5 to 7 act as 4) |
| fine_dly | input | 5 | Fine delay in converter clocks |
| out_i | output | DW | Delayed in-phase sample at converter rate |
| out_q | output | DW | Delayed quadrature sample at converter rate |

## Verification
The bench sends a single-sample impulse for each setting pair, including both ends of each field and the saturating coarse codes. It measures the first cycle of the output and how many cycles the output lasts:
- An off-by-one in the fixed pipeline, or a coarse step that is not L clocks long, moves the first output cycle.
- A coarse stage that shifts on every clock instead of on the strobe also moves the first output cycle.
- An upsampler that does not hold its sample gives a burst of the wrong length.
- Unsaturated codes 5 to 7 would read stale or out-of-range taps.

A setting change on the impulse edge checks that the new value is captured and applied without a reset. A reset with an impulse in flight checks that old history never leaks out afterwards.

// File: rtl/txdly_pkg.sv
// Package txdly_pkg
// Shared constants and helpers for the split coarse/fine transmit delay.
// Assumes the coarse field is narrow enough for the clamp to work on a small vector.
package txdly_pkg;

    // Number of coarse steps, counting zero (coarse delay runs 0..COARSE_STEPS-1).
    localparam int unsigned COARSE_STEPS = 5;

    // Clamp a raw coarse code to the largest legal step count.
    function automatic logic [2:0] clamp_coarse(input logic [2:0] raw_code);
        logic [2:0] top_code;
        top_code = 3'(COARSE_STEPS - 1);
        return (raw_code > top_code) ? top_code : raw_code;
    endfunction

endpackage

// File: rtl/txdly_coarse.sv
// Module txdly_coarse
// Coarse delay line that runs at twice the input rate. A register of NTAP
// packed I/Q entries shifts only on the strobe. The saturated step count
// is captured on the strobe and selects which entry is read.
// Assumes: the strobe is one clock wide; raw codes above NTAP-1 saturate.
module txdly_coarse #(
    parameter int unsigned PW   = 32,
    parameter int unsigned CW   = 3,
    parameter int unsigned NTAP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [PW-1:0] din,
    input  logic [CW-1:0] sel_raw,
    output logic [PW-1:0] tap
);
    localparam logic [CW-1:0] SEL_MAX = CW'(NTAP - 1);

    logic [PW-1:0] line_q [NTAP];
    logic [CW-1:0] sel_q;
    logic [CW-1:0] sel_sat;

    // Saturate the raw code to the last tap.
    always_comb sel_sat = (sel_raw > SEL_MAX) ? SEL_MAX : sel_raw;

    // Latch the coarse setting on the strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)   sel_q <= '0;
        else if (stb) sel_q <= sel_sat;
    end

    // Shift the line on the strobe; entry 0 takes the new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAP; k++) line_q[k] <= '0;
        end else if (stb) begin
            line_q[0] <= din;
            for (int k = 1; k < NTAP; k++) line_q[k] <= line_q[k-1];
        end
    end

    // Read the selected entry.
    always_comb tap = line_q[sel_q];

    // R3: codes above the last step become the last step
    a_r3_coarse_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sel_raw >= SEL_MAX) |=> (sel_q == SEL_MAX));

    // R4: the line is frozen between strobes
    a_r4_coarse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(line_q[0]) && $stable(line_q[NTAP-1])));

    // R7: the setting only moves on a strobe
    a_r7_coarse_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(sel_q));
endmodule

// File: rtl/txdly_hold_up.sv
// Module txdly_hold_up
// Integer-factor sample-hold upsampler. One clock after each strobe it
// loads the coarse-stage output and then holds it until the next strobe.
// The strobe repeats every L clocks, so each value is shown for L clocks.
// Assumes: the strobe period is the upsampling factor.
module txdly_hold_up #(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    logic stb_d;

    // Delay the strobe so the shifted coarse line is read after it settles.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= stb;
    end

    // Load a new held value once per strobe period.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (stb_d) dout <= din;
    end

    // R4: the held value repeats until the next load
    a_r4_hold_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_d |=> $stable(dout));
endmodule

// File: rtl/txdly_fine.sv
// Module txdly_fine
// Fine delay line at the converter clock. A register of DEPTH entries
// shifts every clock. The fine setting is captured on the strobe, and a
// registered read of the selected entry drives the outputs.
// Assumes: DEPTH equals 2**FW, so every code has a tap.
module txdly_fine #(
    parameter int unsigned PW    = 32,
    parameter int unsigned FW    = 5,
    parameter int unsigned DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [FW-1:0] sel_raw,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    logic [PW-1:0] line_q [DEPTH];
    logic [FW-1:0] sel_q;

    // Latch the fine setting on the strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)   sel_q <= '0;
        else if (stb) sel_q <= sel_raw;
    end

    // Shift the line every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else begin
            line_q[0] <= din;
            for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
        end
    end

    // Register the selected tap onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= line_q[sel_q];
    end

    // R5: every entry is one clock older than its neighbour
    a_r5_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_q[1] == $past(line_q[0])));

    // R5: the last entry is DEPTH-1 clocks behind the first
    a_r5_fine_end: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_q[DEPTH-1] == $past(line_q[DEPTH-2])));
endmodule

// File: rtl/tx_iq_delay_split.sv
// Module tx_iq_delay_split
// Programmable two-stage delay for one complex transmit channel. I and Q
// are packed into one word so that both lanes share every register. The
// packed word goes through the coarse line (on the strobe), then the
// sample-hold upsampler, then the fine line (every clock).
// Assumes: hs_valid is high for one clock out of every L; one instance per channel.
module tx_iq_delay_split #(
    parameter int unsigned DW    = 16,
    parameter int unsigned L     = 2,
    parameter int unsigned CW    = 3,
    parameter int unsigned FW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    input  logic [CW-1:0] coarse_dly,
    input  logic [FW-1:0] fine_dly,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q
);
    import txdly_pkg::*;

    localparam int unsigned PW     = 2 * DW;
    localparam int unsigned FDEPTH = 1 << FW;

    logic [PW-1:0] pk_in;
    logic [PW-1:0] coarse_tap;
    logic [PW-1:0] held;
    logic [PW-1:0] pk_out;

    // Pack the two lanes into one word.
    always_comb pk_in = {in_i, in_q};

    txdly_coarse #(.PW(PW), .CW(CW), .NTAP(COARSE_STEPS)) i_coarse (
        .clk(clk), .rst_n(rst_n), .stb(hs_valid),
        .din(pk_in), .sel_raw(coarse_dly), .tap(coarse_tap)
    );

    txdly_hold_up #(.PW(PW)) i_hold (
        .clk(clk), .rst_n(rst_n), .stb(hs_valid),
        .din(coarse_tap), .dout(held)
    );

    txdly_fine #(.PW(PW), .FW(FW), .DEPTH(FDEPTH)) i_fine (
        .clk(clk), .rst_n(rst_n), .stb(hs_valid),
        .sel_raw(fine_dly), .din(held), .dout(pk_out)
    );

    // Split the word back into its lanes.
    always_comb begin
        out_i = pk_out[PW-1:DW];
        out_q = pk_out[DW-1:0];
    end

    // R1: a reset edge leaves both outputs at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (out_i == '0 && out_q == '0));

    // R7: outputs never carry unknown values once out of reset
    a_r7_no_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !$isunknown({out_i, out_q}));
endmodule

// File: tb/test_tx_iq_delay_split.sv
module test_tx_iq_delay_split;
    localparam int DW = 16;
    localparam int L  = 2;
    localparam int BASE = 3;
    localparam int NVEC = 12;
    localparam int WIN  = 80;

    // Each entry is {coarse[2:0], fine[4:0]}.
    localparam logic [7:0] VEC [NVEC] = '{
        {3'd0, 5'd0},  {3'd1, 5'd0},  {3'd2, 5'd0},  {3'd3, 5'd0},
        {3'd4, 5'd0},  {3'd0, 5'd1},  {3'd0, 5'd31}, {3'd4, 5'd31},
        {3'd5, 5'd3},  {3'd6, 5'd7},  {3'd7, 5'd31}, {3'd2, 5'd17}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hs_valid = 1'b0;
    logic [DW-1:0] in_i = '0, in_q = '0;
    logic [2:0]    coarse_dly = '0;
    logic [4:0]    fine_dly = '0;
    logic [DW-1:0] out_i, out_q;

    int checks = 0, errors = 0, ph = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_iq_delay_split #(.DW(DW), .L(L)) i_tx_iq_delay_split (
        .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .in_i(in_i), .in_q(in_q),
        .coarse_dly(coarse_dly), .fine_dly(fine_dly), .out_i(out_i), .out_q(out_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: step at the falling edge and regenerate the strobe.
    task automatic tick();
        @(negedge clk);
        ph = (ph + 1) % L;
        hs_valid = (ph == 0);
    endtask

    // Send one impulse and measure where and how long it shows up.
    task automatic impulse(input int c, input int f, input bit late_set,
                           input logic [DW-1:0] di, output int first, output int cnt,
                           output int bad, output int unk);
        if (!late_set) begin coarse_dly = 3'(c); fine_dly = 5'(f); end
        in_i = '0; in_q = '0;
        repeat (60) tick();
        while (!hs_valid) tick();
        in_i = di; in_q = ~di;
        if (late_set) begin coarse_dly = 3'(c); fine_dly = 5'(f); end
        tick();
        in_i = '0; in_q = '0;
        first = -1; cnt = 0; bad = 0; unk = 0;
        for (int k = 0; k < WIN; k++) begin
            if ($isunknown({out_i, out_q})) unk++;
            else if (out_i != '0) begin
                if (first < 0) first = k;
                cnt++;
                if (out_i != di || out_q != ~di) bad++;
            end
            tick();
        end
    endtask

    initial begin
        int first, cnt, bad, unk, cef, exp_lat;
        // R1: outputs zero during and right after reset even with input driven
        in_i = 16'hAAAA; in_q = 16'h5555; hs_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk(out_i == '0 && out_q == '0, "R1 reset value", int'(out_i), 0);
        in_i = '0; in_q = '0;
        rst_n = 1'b1;
        tick();
        chk(out_i == '0 && out_q == '0, "R1 after release", int'(out_i), 0);

        // Table walk over setting pairs.
        for (int v = 0; v < NVEC; v++) begin
            int c, f;
            c = int'(VEC[v][7:5]);
            f = int'(VEC[v][4:0]);
            cef = (c > 4) ? 4 : c;
            exp_lat = BASE + cef * L + f;
            impulse(c, f, 1'b0, DW'(16'h1200 + v), first, cnt, bad, unk);
            if (c > 4)       chk(first == exp_lat, "R3 saturated latency", first, exp_lat);
            else if (f != 0) chk(first == exp_lat, "R5 fine latency", first, exp_lat);
            else             chk(first == exp_lat, "R2 R8 coarse latency", first, exp_lat);
            chk(cnt == L, "R4 hold repeat length", cnt, L);
            chk(bad == 0, "R6 I/Q identical", bad, 0);
            chk(unk == 0, "R7 no unknown", unk, 0);
        end

        // R8: adjacent coarse steps differ by L clocks
        begin
            int f1, f2;
            impulse(1, 4, 1'b0, 16'h0777, f1, cnt, bad, unk);
            impulse(2, 4, 1'b0, 16'h0778, f2, cnt, bad, unk);
            chk(f2 - f1 == L, "R8 coarse step size", f2 - f1, L);
        end

        // R7: settings changed on the impulse edge apply with no reset
        impulse(3, 9, 1'b1, 16'h0BEE, first, cnt, bad, unk);
        chk(first == BASE + 3 * L + 9, "R7 change on strobe", first, BASE + 3 * L + 9);
        chk(unk == 0, "R7 no unknown after change", unk, 0);

        // R1: reset with an impulse in flight discards it
        coarse_dly = 3'd4; fine_dly = 5'd31;
        repeat (60) tick();
        while (!hs_valid) tick();
        in_i = 16'h0F0F; in_q = 16'hF0F0;
        tick();
        in_i = '0; in_q = '0;
        repeat (10) tick();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        cnt = 0;
        for (int k = 0; k < WIN; k++) begin
            if (out_i != '0 || out_q != '0) cnt++;
            tick();
        end
        chk(cnt == 0, "R1 history cleared by reset", cnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule